// File: doc/BRIEF.md
# FIFO Level Watermark Monitor

This block wraps a wide first-in first-out buffer and reports how full it is through a two-word register port. The control word holds a programmable capacity limit in buffer words, a 4-bit scratch field for software, and a reporting-mode bit. The status word returns either the live fill count or a sticky watermark. The watermark is the lowest level seen since the last clear on a consumer-side instance, or the highest level seen on a producer-side instance. A low-water mark shows how close the consumer came to running dry. A high-water mark shows how close the producer came to overflowing.

The tracking direction is fixed per instance by a parameter. Software clears the watermark by writing the control word with the mode bit set. That write loads the watermark with the fill level present in the cycle of the write. From then on the watermark is folded with the live level on every clock.

Top module: `fifo_level_watch`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, the watermark is 0, and the control word reads 0x00000010 for the default physical depth of 16: limit 16, scratch 0, mode 0.
- R2: Accepted pushes and pops leave the buffer in first-in first-out order with `pop_data` showing the oldest entry. The level rises by one on an accepted push and falls by one on an accepted pop. It is unchanged when both are accepted in the same cycle.
- R3: A push while `full` is 1 is dropped and the level does not change. A pop in the same cycle is still accepted.
- R4: A pop while `empty` is 1 is dropped and the level does not change. A push in the same cycle is still accepted.
- R5: `full` is 1 exactly when the level is at least the effective capacity. The effective capacity is the smaller of control bits [23:0] and the physical depth.
- R6: Control bits [27:24] read back as last written and change neither the level nor the flags. Control bits [30:28] read as 0.
- R7: With control bit 31 at 0, the status word (`reg_sel`=1) returns the live level in bits [23:0] and 0 in bits [31:24].
- R8: With control bit 31 at 1, status bits [23:0] return the watermark. The watermark takes in a level change on the clock edge after the level register changes.
- R9: With `TRACK_MAX`=0, the watermark becomes the smaller of its value and the live level on every clock, so it never rises except through a clear.
- R10: With `TRACK_MAX`=1, the watermark becomes the larger of its value and the live level on every clock, so it never falls except through a clear.
- R11: A control write (`reg_sel`=0) with bit 31 set loads the watermark with the level present in the cycle of the write.
- R12: A write with `reg_sel`=1 is ignored. The control word and the level remain as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Write request |
| push_data | input | DATA_W | Word to store |
| pop | input | 1 | Read request |
| pop_data | output | DATA_W | Oldest stored word |
| full | output | 1 | Level has reached the effective capacity |
| empty | output | 1 | Level is zero |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |

## Verification
A min-tracking instance and a max-tracking instance take the same traffic, so one stimulus separates the two directions. The traffic falls below the cleared level and then climbs above it. This exposes a watermark that follows the wrong direction, that ignores a clear, or that simply mirrors the live level. A table of push, pop and combined requests, including pops against an empty buffer and push-plus-pop at empty, separates a correct level counter from one that accepts a dropped request. Capacity limits below, equal to and above the physical depth check that the limit clamps correctly.

// File: rtl/fifo_level_watch.sv
module fifo_level_watch #(
  parameter int DATA_W     = 256,
  parameter int PHYS_DEPTH = 16,
  parameter bit TRACK_MAX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int LVW = $clog2(PHYS_DEPTH + 1);
  localparam int PTW = $clog2(PHYS_DEPTH);
  localparam logic [23:0] PHYS24 = 24'(PHYS_DEPTH);
  localparam logic [PTW-1:0] LAST_PTR = PTW'(PHYS_DEPTH - 1);

  logic [DATA_W-1:0] mem [PHYS_DEPTH];
  logic [PTW-1:0] wr_ptr, rd_ptr;
  logic [LVW-1:0] level_q, extreme_q, folded;
  logic [23:0] depth_q, eff_depth, level24;
  logic [3:0]  scratch_q;
  logic        mode_q;
  logic        do_push, do_pop, ctrl_wr, clear;
  logic        unused_bits;

  assign unused_bits = ^reg_wdata[30:28];

  assign eff_depth = (depth_q > PHYS24) ? PHYS24 : depth_q;
  assign level24   = 24'(level_q);
  assign full      = level24 >= eff_depth;
  assign empty     = level_q == '0;
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign ctrl_wr   = reg_we && !reg_sel;
  assign clear     = ctrl_wr && reg_wdata[31];
  assign pop_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q   <= PHYS24;
      scratch_q <= '0;
      mode_q    <= 1'b0;
    end else if (ctrl_wr) begin
      depth_q   <= reg_wdata[23:0];
      scratch_q <= reg_wdata[27:24];
      mode_q    <= reg_wdata[31];
    end
  end

  generate
    if (TRACK_MAX) begin : g_max
      assign folded = (level_q > extreme_q) ? level_q : extreme_q;
    end else begin : g_min
      assign folded = (level_q < extreme_q) ? level_q : extreme_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     extreme_q <= '0;
    else if (clear) extreme_q <= level_q;
    else            extreme_q <= folded;
  end

  assign reg_rdata = reg_sel
    ? {8'h00, mode_q ? 24'(extreme_q) : level24}
    : {mode_q, 3'b000, scratch_q, depth_q};

  assert_push_and_pop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> level_q == $past(level_q));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> level_q == $past(level_q));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> level_q == $past(level_q));

  assert_level_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVW'(PHYS_DEPTH));

  assert_scratch_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (reg_sel || reg_rdata[27:24] == $past(reg_wdata[27:24])));

  assert_clear_loads_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> extreme_q == $past(level_q));

  assert_status_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel) |=> (depth_q == $past(depth_q) && mode_q == $past(mode_q)));

  generate
    if (TRACK_MAX) begin : g_chk_max
      assert_watermark_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> extreme_q >= $past(extreme_q));
    end else begin : g_chk_min
      assert_watermark_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> extreme_q <= $past(extreme_q));
    end
  endgenerate
endmodule

// File: tb/sim_fifo_level_watch.sv
`timescale 1ns/1ps
module sim_fifo_level_watch;
  localparam int DW = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [DW-1:0] pd0, pd1;
  logic full0, empty0, full1, empty1;
  logic [31:0] rd0, rd1;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fifo_level_watch #(.DATA_W(DW), .PHYS_DEPTH(16), .TRACK_MAX(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pd0), .full(full0), .empty(empty0), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rd0));

  fifo_level_watch #(.DATA_W(DW), .PHYS_DEPTH(16), .TRACK_MAX(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pd1), .full(full1), .empty(empty1), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rd1));

  // bit 9 push, bit 8 pop, bits 7:0 expected level afterwards
  localparam logic [9:0] VEC [14] = '{
    10'h201, 10'h202, 10'h203, 10'h204, 10'h205, 10'h104, 10'h103,
    10'h303, 10'h102, 10'h101, 10'h100, 10'h100, 10'h301, 10'h100};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic op(input logic p, input logic q, input logic [31:0] d);
    push = p; pop = q; push_data = {{(DW-32){1'b1}}, d};
    @(posedge clk); #2;
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel);
    reg_sel = sel; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(1'b0); chk("R1 control", rd0, 32'h0000_0010); chk("R1 control max", rd1, 32'h0000_0010);
    rd(1'b1); chk("R1 status", rd0, 32'h0); chk("R1 status max", rd1, 32'h0);
    chk("R1 flags", {30'b0, empty0, full0}, 32'h2);

    // R2 R3 R4 R7 table walk
    foreach (VEC[i]) begin
      op(VEC[i][9], VEC[i][8], 32'(i));
      rd(1'b1);
      chk("R2/R4 level R7", rd0, 32'(VEC[i][7:0]));
      chk("R2/R4 level max R7", rd1, 32'(VEC[i][7:0]));
    end

    // R2 order
    op(1, 0, 32'hA1); op(1, 0, 32'hA2); op(1, 0, 32'hA3);
    chk("R2 head", pd0[31:0], 32'hA1);
    chk("R2 head upper", {31'b0, pd0[DW-1:32] == '1}, 32'h1);
    op(0, 1, 0); chk("R2 second", pd0[31:0], 32'hA2);
    op(0, 1, 0); chk("R2 third", pd1[31:0], 32'hA3);
    op(0, 1, 0); rd(1'b1); chk("R2 drained", rd0, 32'h0);

    // R5 R3 capacity limit 4
    wr(1'b0, 32'h0000_0004);
    for (int k = 0; k < 6; k++) op(1, 0, 32'(k));
    rd(1'b1); chk("R3 capped level", rd0, 32'h4);
    chk("R5 full at limit", {31'b0, full0}, 32'h1);
    op(1, 1, 0); rd(1'b1); chk("R3 pop while full", rd0, 32'h3);
    chk("R5 not full below", {31'b0, full0}, 32'h0);
    op(1, 0, 0);

    // R6 scratch
    wr(1'b0, 32'h7A00_0004);
    rd(1'b0); chk("R6 scratch readback", rd0, 32'h0A00_0004);
    rd(1'b1); chk("R6 level untouched", rd0, 32'h4);
    chk("R6 full untouched", {31'b0, full0}, 32'h1);

    // R5 limit above physical depth
    wr(1'b0, 32'h0A00_0064);
    chk("R5 limit raised", {31'b0, full0}, 32'h0);
    for (int k = 0; k < 13; k++) op(1, 0, 32'(k));
    rd(1'b1); chk("R3 physical cap", rd0, 32'd16);
    chk("R5 full at physical", {31'b0, full1}, 32'h1);
    for (int k = 0; k < 12; k++) op(0, 1, 0);
    rd(1'b1); chk("R2 back to four", rd0, 32'h4);

    // R8 R9 R10 R11 watermarks
    wr(1'b0, 32'h8A00_0064);
    rd(1'b0); chk("R8 mode bit", rd0, 32'h8A00_0064);
    for (int k = 0; k < 3; k++) op(0, 1, 0);
    op(1, 0, 0); op(1, 0, 0); tick();
    rd(1'b1); chk("R9 min", rd0, 32'h1); chk("R10 max", rd1, 32'h4);
    for (int k = 0; k < 3; k++) op(1, 0, 0);
    tick();
    rd(1'b1); chk("R9 min holds", rd0, 32'h1); chk("R10 max rises", rd1, 32'h6);
    wr(1'b0, 32'h8A00_0064); tick();
    rd(1'b1); chk("R11 clear min", rd0, 32'h6); chk("R11 clear max", rd1, 32'h6);
    op(0, 1, 0); tick();
    rd(1'b1); chk("R9 min after pop", rd0, 32'h5); chk("R10 max holds", rd1, 32'h6);

    // R7 back to live level
    wr(1'b0, 32'h0A00_0064);
    rd(1'b1); chk("R7 live min inst", rd0, 32'h5); chk("R7 live max inst", rd1, 32'h5);

    // R12 status write ignored
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b0); chk("R12 control kept", rd0, 32'h0A00_0064);
    rd(1'b1); chk("R12 level kept", rd1, 32'h5);

    // R1 reset in mid-traffic
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    rd(1'b0); chk("R1 control after reset", rd1, 32'h0000_0010);
    rd(1'b1); chk("R1 level after reset", rd0, 32'h0);
    chk("R1 empty after reset", {31'b0, empty1}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule